// File: doc/BRIEF.md
# Subchannel Command Condition-Code Unit

This block keeps a small table of subchannel control words and executes the subchannel commands that a processor issues against that table. The commands are clear, halt, modify, start, resume, test, store and cancel. Each command carries a 32-bit subchannel identifier. The upper half of the identifier must hold the subsystem tag 0x0001, and the lower half selects a table entry. The block judges the entry's validity, enable, pending and busy state in the priority order that belongs to each command. It answers with a 2-bit condition code or an operand-exception flag. Modify and start write back only the control fields they are allowed to touch.

Operands arrive already fetched on a request port that uses a valid/ready handshake. Results leave on a response port one clock after acceptance. The attached channel side reports status changes on a separate event port: final status, intermediate status, path failures and device busy. An event takes the whole cycle, so the request port is not ready while an event is offered. Store returns a snapshot of the addressed control word, which is also how software reads the table.

Top module: `sch_cc_unit`

## Requirements
- R1: A command is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low exactly while ev_valid is high. rsp_valid is high for the single cycle after each acceptance and low otherwise.
- R2: If req_sid[31:16] is not 0x0001, the response has rsp_exc=1, rsp_cc=0 and rsp_info=0, and no table state changes.
- R3: An identifier whose low 16 bits are 16 or more names an absent subchannel. Clear, halt, resume, test and cancel return cc3 if the subchannel is absent, not valid, or not enabled.
- R4: Modify returns cc3 only for an absent subchannel. For a present but not-valid entry it returns cc0 and changes nothing.
- R5: Modify on a valid entry returns cc1 if status is pending and not intermediate. Otherwise it returns cc2 if the entry is busy. Either way nothing changes.
- R6: A modify that passes its checks returns cc0. It copies these fields from req_word: mbi [63:48], lpm [47:40], pom [39:32], enable [31], limit mode [30:29], measurement mode [28:27], multipath [26], subclass [25:23] and concurrent sense [22]. It also copies req_parm into the interruption parameter. Every other field is kept, and the priority field is loaded from the subclass.
- R7: Modify raises an operand exception if req_word[21:0] is nonzero or the limit mode field is 2'b11. Nothing changes.
- R8: Start returns cc3 if the subchannel is absent, not valid or not enabled, or if req_word[7:0] AND the path-available mask (default 0xF0) is zero. Nothing changes in that case. Once that check passes, start clears the path-not-operational mask and loads lpm from req_word[7:0], whatever the final code is.
- R9: After the path check passes, start returns cc1 if status is pending and cc2 if the entry is busy. Otherwise it returns cc0, sets busy and sets the last-path-used mask to 0x80.
- R10: Start raises an operand exception if req_parm[31] is set or if any flag in req_word[15:12] is set. Nothing changes.
- R11: Store returns cc3 with rsp_info=0 for an absent subchannel. Otherwise it returns cc0 with the control word before the command on rsp_info and the interruption parameter on rsp_parm. rsp_info layout: mbi[64:49], lpm[48:41], pom[40:33], en[32], lm[31:30], mm[29:28], mp[27], isc[26:24], cs[23], valid[22], pending[21], intermediate[20], busy[19], priority[18:16], pnom[15:8], lpum[7:0]. Every other command returns rsp_info=0 and rsp_parm=0.
- R12: On a usable entry the other commands behave as follows:
  - Clear returns cc0 and clears pending, intermediate and busy.
  - Halt returns cc1 if status is pending and not intermediate. Otherwise it returns cc0, clears busy, sets pending and clears intermediate.
  - Resume returns cc1 if pending, cc2 if not busy, and otherwise cc0 with no change.
  - Test returns cc0 and clears pending and intermediate if pending. Otherwise it returns cc1.
  - Cancel returns cc1 if pending, cc2 if not busy, and otherwise cc0 and clears busy.
- R13: An event on ev_idx with ev_kind applies at the clock edge:
  - Kind 0 sets pending, clears intermediate and clears busy.
  - Kind 1 sets pending and intermediate.
  - Kind 2 ORs ev_mask into pnom.
  - Kind 3 sets busy.
- R14: After reset, rsp_valid is 0 and every entry is zero except its valid bit, which is taken from VALID_MASK (default: entries 0 to 14 valid, entry 15 not valid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be accepted |
| req_cmd | input | 3 | 0 clear, 1 halt, 2 modify, 3 start, 4 resume, 5 test, 6 store, 7 cancel |
| req_sid | input | 32 | Subsystem tag (upper) and subchannel number (lower) |
| req_word | input | 64 | New control word (modify) or path mask and flags (start) |
| req_parm | input | 32 | Interruption parameter (modify) or channel-program address (start) |
| ev_valid | input | 1 | Channel-side status event |
| ev_idx | input | 4 | Entry the event applies to |
| ev_kind | input | 2 | Event kind |
| ev_mask | input | 8 | Failed paths for kind 2 |
| rsp_valid | output | 1 | Response present |
| rsp_cc | output | 2 | Condition code |
| rsp_exc | output | 1 | Operand exception |
| rsp_info | output | 65 | Store snapshot of the control word |
| rsp_parm | output | 32 | Store snapshot of the interruption parameter |

## Verification
Every response is registered once, at the same edge that accepts the command. It is therefore due one cycle after acceptance. The bench drives each request on a falling edge and reads rsp_cc, rsp_exc, rsp_info and rsp_parm on the next falling edge, between the accepting edge and the one that drops rsp_valid. Effects on the table become visible to the next store command. An event applied on one edge is visible to a store that is accepted at the following edge. Each scenario therefore reads back its state through store right after the stimulus and before the next change.

// File: rtl/sch_pkg.sv
package sch_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR  = 3'd0,
    OP_HALT   = 3'd1,
    OP_MODIFY = 3'd2,
    OP_START  = 3'd3,
    OP_RESUME = 3'd4,
    OP_TEST   = 3'd5,
    OP_STORE  = 3'd6,
    OP_CANCEL = 3'd7
  } sch_op_e;

  typedef enum logic [1:0] {
    EV_FINAL = 2'd0,
    EV_INTER = 2'd1,
    EV_PATHF = 2'd2,
    EV_BUSY  = 2'd3
  } sch_ev_e;

  // Control word held per subchannel; the packed order is the store layout.
  typedef struct packed {
    logic [15:0] mbi;
    logic [7:0]  lpm;
    logic [7:0]  pom;
    logic        en;
    logic [1:0]  lm;
    logic [1:0]  mm;
    logic        mp;
    logic [2:0]  isc;
    logic        cs;
    logic        vld;
    logic        pend;
    logic        inter;
    logic        busy;
    logic [2:0]  pri;
    logic [7:0]  pnom;
    logic [7:0]  lpum;
  } sch_ctl_t;

  localparam int unsigned CTL_W     = $bits(sch_ctl_t);
  localparam logic [15:0] SSID_TAG  = 16'h0001;
  localparam logic [1:0]  LM_RESV   = 2'b11;
  localparam logic [7:0]  LPUM_INIT = 8'h80;

endpackage

// File: rtl/sch_decode.sv
module sch_decode #(
  parameter int unsigned NUM_SCH = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_SCH)
) (
  input  logic [31:0]      sid,
  output logic             sid_ok,
  output logic             present,
  output logic [IDX_W-1:0] idx
);
  import sch_pkg::*;

  assign sid_ok  = (sid[31:16] == SSID_TAG);
  assign present = ({16'd0, sid[15:0]} < 32'(NUM_SCH));
  assign idx     = sid[IDX_W-1:0];

endmodule

// File: rtl/sch_event.sv
module sch_event (
  input  sch_pkg::sch_ctl_t cur,
  input  logic [1:0]        kind,
  input  logic [7:0]        mask,
  output sch_pkg::sch_ctl_t nxt
);
  import sch_pkg::*;

  always_comb begin
    nxt = cur;
    case (sch_ev_e'(kind))
      EV_FINAL: begin
        nxt.pend  = 1'b1;
        nxt.inter = 1'b0;
        nxt.busy  = 1'b0;
      end
      EV_INTER: begin
        nxt.pend  = 1'b1;
        nxt.inter = 1'b1;
      end
      EV_PATHF: nxt.pnom = cur.pnom | mask;
      EV_BUSY:  nxt.busy = 1'b1;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/sch_cmd.sv
module sch_cmd #(
  parameter logic [7:0] PAM = 8'hF0
) (
  input  logic [2:0]        cmd,
  input  logic              sid_ok,
  input  logic              present,
  input  logic [63:0]       word,
  input  logic              parm_msb,
  input  sch_pkg::sch_ctl_t cur,
  output logic [1:0]        cc,
  output logic              exc,
  output logic              wr_en,
  output logic              ip_we,
  output sch_pkg::sch_ctl_t nxt
);
  import sch_pkg::*;

  sch_op_e op;
  logic    usable;
  logic    hard_pend;
  logic    mod_bad;
  logic    start_bad;
  logic    fmt_err;

  assign op        = sch_op_e'(cmd);
  assign usable    = present && cur.vld && cur.en;
  assign hard_pend = cur.pend && !cur.inter;
  assign mod_bad   = (word[21:0] != 22'd0) || (word[30:29] == LM_RESV);
  assign start_bad = (word[15:12] != 4'd0) || parm_msb;
  assign fmt_err   = ((op == OP_MODIFY) && mod_bad) || ((op == OP_START) && start_bad);

  always_comb begin
    cc    = 2'd0;
    exc   = 1'b0;
    wr_en = 1'b0;
    ip_we = 1'b0;
    nxt   = cur;
    if (!sid_ok || fmt_err) begin
      exc = 1'b1;
    end else begin
      case (op)
        OP_MODIFY: begin
          if (!present)       cc = 2'd3;
          else if (!cur.vld)  cc = 2'd0;
          else if (hard_pend) cc = 2'd1;
          else if (cur.busy)  cc = 2'd2;
          else begin
            wr_en    = 1'b1;
            ip_we    = 1'b1;
            nxt.mbi  = word[63:48];
            nxt.lpm  = word[47:40];
            nxt.pom  = word[39:32];
            nxt.en   = word[31];
            nxt.lm   = word[30:29];
            nxt.mm   = word[28:27];
            nxt.mp   = word[26];
            nxt.isc  = word[25:23];
            nxt.cs   = word[22];
            nxt.pri  = word[25:23];
          end
        end
        OP_START: begin
          if (!usable || ((word[7:0] & PAM) == 8'd0)) begin
            cc = 2'd3;
          end else begin
            wr_en    = 1'b1;
            nxt.pnom = 8'd0;
            nxt.lpm  = word[7:0];
            if (cur.pend)      cc = 2'd1;
            else if (cur.busy) cc = 2'd2;
            else begin
              nxt.busy = 1'b1;
              nxt.lpum = LPUM_INIT;
            end
          end
        end
        OP_STORE: cc = present ? 2'd0 : 2'd3;
        default: begin
          if (!usable) begin
            cc = 2'd3;
          end else begin
            case (op)
              OP_CLEAR: begin
                wr_en     = 1'b1;
                nxt.pend  = 1'b0;
                nxt.inter = 1'b0;
                nxt.busy  = 1'b0;
              end
              OP_HALT: begin
                if (hard_pend) cc = 2'd1;
                else begin
                  wr_en     = 1'b1;
                  nxt.busy  = 1'b0;
                  nxt.pend  = 1'b1;
                  nxt.inter = 1'b0;
                end
              end
              OP_RESUME: begin
                if (cur.pend)       cc = 2'd1;
                else if (!cur.busy) cc = 2'd2;
              end
              OP_TEST: begin
                if (cur.pend) begin
                  wr_en     = 1'b1;
                  nxt.pend  = 1'b0;
                  nxt.inter = 1'b0;
                end else cc = 2'd1;
              end
              OP_CANCEL: begin
                if (cur.pend)       cc = 2'd1;
                else if (!cur.busy) cc = 2'd2;
                else begin
                  wr_en    = 1'b1;
                  nxt.busy = 1'b0;
                end
              end
              default: cc = 2'd0;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sch_table.sv
module sch_table #(
  parameter int unsigned        NUM_SCH    = 16,
  parameter int unsigned        IDX_W      = $clog2(NUM_SCH),
  parameter logic [NUM_SCH-1:0] VALID_MASK = {1'b0, {(NUM_SCH-1){1'b1}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output sch_pkg::sch_ctl_t rd_ctl,
  output logic [31:0]       rd_ip,
  input  logic [IDX_W-1:0]  ev_idx,
  output sch_pkg::sch_ctl_t ev_cur,
  input  logic              wr_en,
  input  logic              ip_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  sch_pkg::sch_ctl_t wr_ctl,
  input  logic [31:0]       wr_ip,
  input  logic              ev_en,
  input  sch_pkg::sch_ctl_t ev_ctl
);
  import sch_pkg::*;

  sch_ctl_t    ctl_q [NUM_SCH];
  logic [31:0] ip_q  [NUM_SCH];

  assign rd_ctl = (32'(rd_idx) < NUM_SCH) ? ctl_q[rd_idx] : '0;
  assign rd_ip  = (32'(rd_idx) < NUM_SCH) ? ip_q[rd_idx]  : '0;
  assign ev_cur = (32'(ev_idx) < NUM_SCH) ? ctl_q[ev_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SCH; i++) begin
        ctl_q[i]     <= '0;
        ctl_q[i].vld <= VALID_MASK[i];
        ip_q[i]      <= '0;
      end
    end else if (wr_en && (32'(wr_idx) < NUM_SCH)) begin
      ctl_q[wr_idx] <= wr_ctl;
      if (ip_we) ip_q[wr_idx] <= wr_ip;
    end else if (ev_en && (32'(ev_idx) < NUM_SCH)) begin
      ctl_q[ev_idx] <= ev_ctl;
    end
  end

  // R1
  port_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ev_en));

endmodule

// File: rtl/sch_cc_unit.sv
module sch_cc_unit #(
  parameter int unsigned        NUM_SCH    = 16,
  parameter int unsigned        IDX_W      = $clog2(NUM_SCH),
  parameter logic [7:0]         PAM        = 8'hF0,
  parameter logic [NUM_SCH-1:0] VALID_MASK = {1'b0, {(NUM_SCH-1){1'b1}}}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2:0]                 req_cmd,
  input  logic [31:0]                req_sid,
  input  logic [63:0]                req_word,
  input  logic [31:0]                req_parm,
  input  logic                       ev_valid,
  input  logic [IDX_W-1:0]           ev_idx,
  input  logic [1:0]                 ev_kind,
  input  logic [7:0]                 ev_mask,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_cc,
  output logic                       rsp_exc,
  output logic [sch_pkg::CTL_W-1:0]  rsp_info,
  output logic [31:0]                rsp_parm
);
  import sch_pkg::*;

  logic             fire;
  logic             sid_ok;
  logic             present;
  logic [IDX_W-1:0] idx;
  sch_ctl_t         cur_ctl;
  logic [31:0]      cur_ip;
  sch_ctl_t         ev_cur;
  sch_ctl_t         ev_nxt;
  sch_ctl_t         cmd_nxt;
  logic [1:0]       cc_d;
  logic             exc_d;
  logic             wr_d;
  logic             ipwe_d;
  logic             show;

  assign req_ready = !ev_valid;
  assign fire      = req_valid && req_ready;

  sch_decode #(.NUM_SCH(NUM_SCH), .IDX_W(IDX_W)) i_dec (
    .sid(req_sid), .sid_ok(sid_ok), .present(present), .idx(idx)
  );

  sch_cmd #(.PAM(PAM)) i_cmd (
    .cmd(req_cmd), .sid_ok(sid_ok), .present(present), .word(req_word),
    .parm_msb(req_parm[31]), .cur(cur_ctl), .cc(cc_d), .exc(exc_d),
    .wr_en(wr_d), .ip_we(ipwe_d), .nxt(cmd_nxt)
  );

  sch_event i_evt (
    .cur(ev_cur), .kind(ev_kind), .mask(ev_mask), .nxt(ev_nxt)
  );

  sch_table #(.NUM_SCH(NUM_SCH), .IDX_W(IDX_W), .VALID_MASK(VALID_MASK)) i_tab (
    .clk(clk), .rst(rst),
    .rd_idx(idx), .rd_ctl(cur_ctl), .rd_ip(cur_ip),
    .ev_idx(ev_idx), .ev_cur(ev_cur),
    .wr_en(fire && wr_d), .ip_we(ipwe_d), .wr_idx(idx), .wr_ctl(cmd_nxt),
    .wr_ip(req_parm), .ev_en(ev_valid), .ev_ctl(ev_nxt)
  );

  assign show = (sch_op_e'(req_cmd) == OP_STORE) && !exc_d && present;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_cc    <= 2'd0;
      rsp_exc   <= 1'b0;
      rsp_info  <= '0;
      rsp_parm  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_cc   <= cc_d;
        rsp_exc  <= exc_d;
        rsp_info <= show ? cur_ctl : '0;
        rsp_parm <= show ? cur_ip  : '0;
      end
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);
  // R1
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid);
  // R2
  ssid_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_sid[31:16] != 16'h0001) |=> rsp_exc);
  // R2
  exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> (rsp_cc == 2'd0 && rsp_info == '0));
  // R11
  info_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_cmd != 3'd6) |=> (rsp_info == '0 && rsp_parm == 32'd0));

endmodule

// File: tb/test_sch_cc_unit.sv
module test_sch_cc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cmd = 3'd0;
  logic [31:0] req_sid = 32'd0;
  logic [63:0] req_word = 64'd0;
  logic [31:0] req_parm = 32'd0;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_idx = 4'd0;
  logic [1:0]  ev_kind = 2'd0;
  logic [7:0]  ev_mask = 8'd0;
  logic        rsp_valid;
  logic [1:0]  rsp_cc;
  logic        rsp_exc;
  logic [64:0] rsp_info;
  logic [31:0] rsp_parm;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [2:0] C_CLR = 3'd0, C_HLT = 3'd1, C_MOD = 3'd2, C_STA = 3'd3,
                         C_RES = 3'd4, C_TST = 3'd5, C_STO = 3'd6, C_CAN = 3'd7;
  localparam logic [31:0] S3 = 32'h0001_0003;

  always #4 clk = ~clk;

  sch_cc_unit i_sch_cc_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_sid(req_sid), .req_word(req_word), .req_parm(req_parm),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_kind(ev_kind), .ev_mask(ev_mask),
    .rsp_valid(rsp_valid), .rsp_cc(rsp_cc), .rsp_exc(rsp_exc),
    .rsp_info(rsp_info), .rsp_parm(rsp_parm)
  );

  function automatic logic [64:0] mk(input logic [15:0] mbi, input logic [7:0] lpm,
      input logic [7:0] pom, input logic en, input logic [1:0] lm, input logic [1:0] mm,
      input logic mp, input logic [2:0] isc, input logic cs, input logic vld,
      input logic pend, input logic inter, input logic busy, input logic [2:0] pri,
      input logic [7:0] pnom, input logic [7:0] lpum);
    return {mbi, lpm, pom, en, lm, mm, mp, isc, cs, vld, pend, inter, busy, pri, pnom, lpum};
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input logic [31:0] sid,
                     input logic [63:0] w, input logic [31:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_sid = sid; req_word = w; req_parm = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_cc(input string tag, input logic [1:0] cc, input logic exc);
    chk({tag, " valid"}, 96'(rsp_valid), 96'(1));
    chk({tag, " cc"}, 96'(rsp_cc), 96'(cc));
    chk({tag, " exc"}, 96'(rsp_exc), 96'(exc));
  endtask

  task automatic expect_store(input string tag, input logic [31:0] sid,
                              input logic [64:0] info, input logic [31:0] parm);
    cmd(C_STO, sid, 64'd0, 32'd0);
    chk({tag, " store cc"}, 96'(rsp_cc), 96'(0));
    chk({tag, " store info"}, 96'(rsp_info), 96'(info));
    chk({tag, " store parm"}, 96'(rsp_parm), 96'(parm));
  endtask

  task automatic event_in(input logic [3:0] i, input logic [1:0] k, input logic [7:0] m);
    @(negedge clk);
    ev_valid = 1'b1; ev_idx = i; ev_kind = k; ev_mask = m;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // Modify words: {mbi, lpm, pom, en, lm, mm, mp, isc, cs, 22'd0}
  localparam logic [63:0] MW1 = {16'hA5C3, 8'hF0, 8'h0F, 1'b1, 2'b01, 2'b10, 1'b1, 3'd5, 1'b1, 22'd0};
  localparam logic [63:0] MW2 = {16'h1234, 8'hF0, 8'h55, 1'b1, 2'b10, 2'b01, 1'b0, 3'd2, 1'b0, 22'd0};

  task automatic t_reset;
    chk("R14 rsp_valid after reset", 96'(rsp_valid), 96'(0));
    chk("R1 ready idle", 96'(req_ready), 96'(1));
    expect_store("R14 entry3", S3, mk(0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0), 0);
    expect_store("R14 entry15", 32'h0001_000F, 65'd0, 0);
  endtask

  task automatic t_ssid;
    cmd(C_CLR, 32'h0002_0003, 64'd0, 32'd0);
    expect_cc("R2 clear bad tag", 2'd0, 1'b1);
    chk("R2 info zero", 96'(rsp_info), 96'(0));
    cmd(C_MOD, 32'h0000_0003, MW1, 32'h1111_1111);
    expect_cc("R2 modify bad tag", 2'd0, 1'b1);
    expect_store("R2 unchanged", S3, mk(0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0), 0);
  endtask

  task automatic t_absent;
    cmd(C_CLR, 32'h0001_0010, 64'd0, 32'd0); expect_cc("R3 clear absent 16", 2'd3, 1'b0);
    cmd(C_HLT, S3, 64'd0, 32'd0);            expect_cc("R3 halt disabled", 2'd3, 1'b0);
    cmd(C_TST, 32'h0001_000F, 64'd0, 32'd0); expect_cc("R3 test invalid", 2'd3, 1'b0);
    cmd(C_RES, S3, 64'd0, 32'd0);            expect_cc("R3 resume disabled", 2'd3, 1'b0);
    cmd(C_CAN, S3, 64'd0, 32'd0);            expect_cc("R3 cancel disabled", 2'd3, 1'b0);
    cmd(C_STA, S3, 64'h00F0, 32'd0);         expect_cc("R8 start disabled", 2'd3, 1'b0);
    cmd(C_STO, 32'h0001_0020, 64'd0, 32'd0); expect_cc("R11 store absent", 2'd3, 1'b0);
    chk("R11 store absent info", 96'(rsp_info), 96'(0));
  endtask

  task automatic t_modify;
    cmd(C_MOD, 32'h0001_000F, MW1, 32'h7777_7777); expect_cc("R4 modify invalid", 2'd0, 1'b0);
    expect_store("R4 invalid untouched", 32'h0001_000F, 65'd0, 0);
    cmd(C_MOD, 32'h0001_0028, MW1, 32'd0); expect_cc("R4 modify absent", 2'd3, 1'b0);
    cmd(C_MOD, S3, MW1, 32'hDEAD_BEEF);    expect_cc("R6 modify ok", 2'd0, 1'b0);
    expect_store("R6 fields", S3,
      mk(16'hA5C3,8'hF0,8'h0F,1,2'b01,2'b10,1,3'd5,1,1,0,0,0,3'd5,0,0), 32'hDEAD_BEEF);
    cmd(C_MOD, S3, MW2 | 64'h20, 32'd1); expect_cc("R7 reserved bit", 2'd0, 1'b1);
    cmd(C_MOD, S3, MW2 | (64'h3 << 29), 32'd1); expect_cc("R7 limit mode 11", 2'd0, 1'b1);
    expect_store("R7 unchanged", S3,
      mk(16'hA5C3,8'hF0,8'h0F,1,2'b01,2'b10,1,3'd5,1,1,0,0,0,3'd5,0,0), 32'hDEAD_BEEF);
  endtask

  task automatic t_start;
    event_in(4'd3, 2'd2, 8'h3C);
    cmd(C_STA, S3, 64'h000F, 32'd0); expect_cc("R8 no common path", 2'd3, 1'b0);
    expect_store("R13 pnom set, R8 untouched", S3,
      mk(16'hA5C3,8'hF0,8'h0F,1,2'b01,2'b10,1,3'd5,1,1,0,0,0,3'd5,8'h3C,0), 32'hDEAD_BEEF);
    cmd(C_STA, S3, 64'h1030, 32'd0);        expect_cc("R10 reserved flag", 2'd0, 1'b1);
    cmd(C_STA, S3, 64'h0030, 32'h8000_0000); expect_cc("R10 address msb", 2'd0, 1'b1);
    cmd(C_STA, S3, 64'h0030, 32'h0000_1000); expect_cc("R9 start ok", 2'd0, 1'b0);
    expect_store("R9 started", S3,
      mk(16'hA5C3,8'h30,8'h0F,1,2'b01,2'b10,1,3'd5,1,1,0,0,1,3'd5,0,8'h80), 32'hDEAD_BEEF);
    cmd(C_STA, S3, 64'h0030, 32'd0); expect_cc("R9 start busy", 2'd2, 1'b0);
    cmd(C_MOD, S3, MW2, 32'd5);      expect_cc("R5 modify busy", 2'd2, 1'b0);
  endtask

  task automatic t_events;
    event_in(4'd3, 2'd1, 8'd0);
    cmd(C_MOD, S3, MW2, 32'd5); expect_cc("R5 intermediate then busy", 2'd2, 1'b0);
    event_in(4'd3, 2'd0, 8'd0);
    cmd(C_MOD, S3, MW2, 32'd5); expect_cc("R5 pending", 2'd1, 1'b0);
    cmd(C_STA, S3, 64'h00C0, 32'd0); expect_cc("R9 start pending", 2'd1, 1'b0);
    expect_store("R13 final status, R8 lpm loaded", S3,
      mk(16'hA5C3,8'hC0,8'h0F,1,2'b01,2'b10,1,3'd5,1,1,1,0,0,3'd5,0,8'h80), 32'hDEAD_BEEF);
    cmd(C_TST, S3, 64'd0, 32'd0); expect_cc("R12 test pending", 2'd0, 1'b0);
    cmd(C_TST, S3, 64'd0, 32'd0); expect_cc("R12 test idle", 2'd1, 1'b0);
    event_in(4'd3, 2'd2, 8'h01);
    cmd(C_MOD, S3, MW2, 32'h0BAD_F00D); expect_cc("R6 second modify", 2'd0, 1'b0);
    expect_store("R6 others kept", S3,
      mk(16'h1234,8'hF0,8'h55,1,2'b10,2'b01,0,3'd2,0,1,0,0,0,3'd2,8'h01,8'h80), 32'h0BAD_F00D);
  endtask

  task automatic t_cmds;
    cmd(C_RES, S3, 64'd0, 32'd0); expect_cc("R12 resume idle", 2'd2, 1'b0);
    cmd(C_CAN, S3, 64'd0, 32'd0); expect_cc("R12 cancel idle", 2'd2, 1'b0);
    event_in(4'd3, 2'd3, 8'd0);
    cmd(C_RES, S3, 64'd0, 32'd0); expect_cc("R12 resume busy", 2'd0, 1'b0);
    cmd(C_CAN, S3, 64'd0, 32'd0); expect_cc("R12 cancel busy", 2'd0, 1'b0);
    expect_store("R12 cancel cleared busy", S3,
      mk(16'h1234,8'hF0,8'h55,1,2'b10,2'b01,0,3'd2,0,1,0,0,0,3'd2,8'h01,8'h80), 32'h0BAD_F00D);
    event_in(4'd3, 2'd3, 8'd0);
    cmd(C_HLT, S3, 64'd0, 32'd0); expect_cc("R12 halt busy", 2'd0, 1'b0);
    cmd(C_HLT, S3, 64'd0, 32'd0); expect_cc("R12 halt pending", 2'd1, 1'b0);
    event_in(4'd3, 2'd3, 8'd0);
    cmd(C_CLR, S3, 64'd0, 32'd0); expect_cc("R12 clear", 2'd0, 1'b0);
    expect_store("R12 clear result", S3,
      mk(16'h1234,8'hF0,8'h55,1,2'b10,2'b01,0,3'd2,0,1,0,0,0,3'd2,8'h01,8'h80), 32'h0BAD_F00D);
  endtask

  task automatic t_ready;
    @(negedge clk);
    ev_valid = 1'b1; ev_idx = 4'd0; ev_kind = 2'd2; ev_mask = 8'd0;
    req_valid = 1'b1; req_cmd = C_TST; req_sid = S3;
    #1 chk("R1 not ready during event", 96'(req_ready), 96'(0));
    @(negedge clk);
    chk("R1 no response while blocked", 96'(rsp_valid), 96'(0));
    ev_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    expect_cc("R1 accepted after event", 2'd1, 1'b0);
    @(negedge clk);
    chk("R1 response one cycle", 96'(rsp_valid), 96'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ssid();
    t_absent();
    t_modify();
    t_start();
    t_events();
    t_cmds();
    t_ready();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule